// File: doc/BRIEF.md
# Uncalibrated DRAM Lane Detector

This block decides whether one DRAM position on a memory port was skipped by calibration. Per-rank bad-DQ bitmaps mark each failing data bit. A DRAM that calibration never touched is marked bad in full on every configured rank. When one configured rank shows any of that DRAM's bits as good, the DRAM was calibrated. The block takes the DRAM width (x4 or x8), the DRAM index, a table of eight rank-pair entries, and the number of ranks on the port. It then reads one bitmap byte per configured rank through a simple request/response port.

A start pulse latches the inputs. The block first resolves the bitmap byte and the nibble or byte mask that belong to the DRAM. It walks the ranks in order and pulses done with the verdict. With the verdict it also returns the mask that repair logic ANDs into the bitmap byte to clear the DRAM's bad bits. A byte index past the end of the bitmap gives an error in place of a verdict. A port with a single rank is reported as calibrated at once, because calibration failure and no calibration cannot be told apart there.

Top module: `uncal_lane_detect`

## Requirements
- R1: With exactly one rank on the port and an in-range index, done pulses in the cycle after start with uncal=0 and no read is issued.
- R2: For x8 parts (width_x8=1) the bitmap byte read (rd_byte) equals the DRAM index.
- R3: For x4 parts (width_x8=0) the bitmap byte read equals the DRAM index shifted right by one.
- R4: The detection mask is 0xFF for x8. For x4 it is 0xF0 for an even index and 0x0F for an odd index. A rank counts as fully bad only when (byte AND mask) equals the mask.
- R5: A rank whose 8-bit rank-pair entry (bits 8r+7:8r of rank_pair) equals 255 is unconfigured: it is never read and never affects the verdict.
- R6: The scan ends at the first configured rank that is not fully bad, with uncal=0, and no rank after it is read.
- R7: If every configured rank is fully bad, including the case of no configured rank, done returns uncal=1.
- R8: clr_mask is 0x00 for x8. For x4 it is 0x0F for an even index and 0xF0 for an odd index. It is valid from done until the next accepted start.
- R9: A byte index at or above BITMAP_BYTES gives done with oob_err=1 and uncal=0 in the cycle after start, with no read.
- R10: Reads go to ranks in ascending order, one per cycle. Each read's data is taken on rd_data in the cycle after the request. done is a single-cycle pulse.
- R11: A start while busy is ignored and does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an evaluation (taken only when idle) |
| width_x8 | input | 1 | 1 = x8 DRAMs, 0 = x4 DRAMs |
| dram_idx | input | IDX_W | DRAM position to evaluate |
| rank_pair | input | 8*NUM_RANKS | Rank-pair entry per rank, 255 = unconfigured |
| rank_cnt | input | CNT_W | Number of ranks on the port |
| rd_req | output | 1 | Bitmap byte read request |
| rd_rank | output | RANK_W | Rank of the read |
| rd_byte | output | BYTE_W | Byte of the read |
| rd_data | input | 8 | Read data, the cycle after rd_req |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Result pulse |
| uncal | output | 1 | 1 = DRAM judged uncalibrated |
| oob_err | output | 1 | Byte index out of range |
| clr_mask | output | 8 | Mask to AND into the bitmap byte after repair |

## Verification
The bench uses the default parameters: eight ranks, a ten-byte bitmap and an 8-bit index. With these the x8 index boundary sits at 9/10 and the x4 boundary at 19/20, and both are exercised. All eight rank slots are reachable, so a full scan, a scan that stops in the middle, and tables with holes of 255 entries all occur. Read traffic is watched for order, for skipped ranks, and for stray reads on the single-rank and error paths.

// File: rtl/uld_pkg.sv
package uld_pkg;
    localparam logic [7:0] NO_PAIR = 8'd255;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_st_e;
endpackage

// File: rtl/uld_lane_sel.sv
module uld_lane_sel #(
    parameter int IDX_W        = 8,
    parameter int BITMAP_BYTES = 10,
    localparam int BYTE_W      = $clog2(BITMAP_BYTES)
) (
    input  logic              width_x8,
    input  logic [IDX_W-1:0]  dram_idx,
    output logic [BYTE_W-1:0] byte_idx,
    output logic [7:0]        det_mask,
    output logic [7:0]        clr_mask,
    output logic              oob
);
    logic [IDX_W-1:0] full_byte;
    logic             odd;

    always_comb begin
        odd       = dram_idx[0];
        full_byte = width_x8 ? dram_idx : (dram_idx >> 1);
        oob       = full_byte >= IDX_W'(BITMAP_BYTES);
        byte_idx  = full_byte[BYTE_W-1:0];
        if (width_x8) begin
            det_mask = 8'hFF;
            clr_mask = 8'h00;
        end else if (!odd) begin
            det_mask = 8'hF0;
            clr_mask = 8'h0F;
        end else begin
            det_mask = 8'h0F;
            clr_mask = 8'hF0;
        end
    end
endmodule

// File: rtl/uld_rank_scan.sv
module uld_rank_scan
    import uld_pkg::*;
#(
    parameter int NUM_RANKS    = 8,
    parameter int BITMAP_BYTES = 10,
    localparam int RANK_W      = $clog2(NUM_RANKS),
    localparam int PTR_W       = RANK_W + 1,
    localparam int CNT_W       = $clog2(NUM_RANKS + 1),
    localparam int BYTE_W      = $clog2(BITMAP_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [8*NUM_RANKS-1:0] rank_pair,
    input  logic [CNT_W-1:0]       rank_cnt,
    input  logic [BYTE_W-1:0]      byte_idx,
    input  logic [7:0]             det_mask,
    input  logic [7:0]             clr_mask_in,
    input  logic                   oob,
    output logic                   rd_req,
    output logic [RANK_W-1:0]      rd_rank,
    output logic [BYTE_W-1:0]      rd_byte,
    input  logic [7:0]             rd_data,
    output logic                   busy,
    output logic                   done,
    output logic                   uncal,
    output logic                   oob_err,
    output logic [7:0]             clr_mask
);
    typedef struct packed {
        scan_st_e          st;
        logic [PTR_W-1:0]  ptr;
        logic              resp_v;
        logic [NUM_RANKS-1:0] vld;
        logic [7:0]        mask;
        logic [BYTE_W-1:0] byt;
        logic [7:0]        clr;
        logic              done;
        logic              uncal;
        logic              err;
    } scan_t;

    scan_t s_d, s_q;
    logic [NUM_RANKS-1:0] cfg_vld;
    logic                 part_good;
    logic                 ptr_end;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_vld
        assign cfg_vld[r] = rank_pair[8*r +: 8] != NO_PAIR;
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        rd_req    = 1'b0;
        rd_rank   = s_q.ptr[RANK_W-1:0];
        ptr_end   = s_q.ptr == PTR_W'(NUM_RANKS);
        part_good = s_q.resp_v && ((rd_data & s_q.mask) != s_q.mask);
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.mask   = det_mask;
                    s_d.byt    = byte_idx;
                    s_d.clr    = clr_mask_in;
                    s_d.vld    = cfg_vld;
                    s_d.ptr    = '0;
                    s_d.resp_v = 1'b0;
                    s_d.uncal  = 1'b0;
                    if (oob) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b1;
                    end else if (rank_cnt == CNT_W'(1)) begin
                        s_d.done = 1'b1;
                        s_d.err  = 1'b0;
                    end else begin
                        s_d.err = 1'b0;
                        s_d.st  = ST_SCAN;
                    end
                end
            end
            default: begin
                if (part_good) begin
                    s_d.done   = 1'b1;
                    s_d.uncal  = 1'b0;
                    s_d.resp_v = 1'b0;
                    s_d.st     = ST_IDLE;
                end else if (ptr_end && !s_q.resp_v) begin
                    s_d.done  = 1'b1;
                    s_d.uncal = 1'b1;
                    s_d.st    = ST_IDLE;
                end else if (!ptr_end) begin
                    rd_req     = s_q.vld[s_q.ptr[RANK_W-1:0]];
                    s_d.resp_v = rd_req;
                    s_d.ptr    = s_q.ptr + PTR_W'(1);
                end else begin
                    s_d.resp_v = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, ptr: '0, resp_v: 1'b0, vld: '0, mask: '0,
                     byt: '0, clr: '0, done: 1'b0, uncal: 1'b0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_byte  = s_q.byt;
    assign busy     = s_q.st == ST_SCAN;
    assign done     = s_q.done;
    assign uncal    = s_q.uncal;
    assign oob_err  = s_q.err;
    assign clr_mask = s_q.clr;

    // R10: result pulse lasts one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: back-to-back reads climb in rank
    a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req)) |-> (rd_rank > $past(rd_rank)));
    // R11: reads only happen inside a scan
    a_r11_req_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> busy);
    // R9: an error result never claims uncalibrated
    a_r9_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (done && oob_err) |-> !uncal);
    // R1: single-rank port resolves next cycle as calibrated
    a_r1_single_rank: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !oob && rank_cnt == CNT_W'(1)) |=> (done && !uncal && !rd_req));
    // R9: out-of-range index resolves next cycle with error, no read
    a_r9_oob_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && oob) |=> (done && oob_err && !rd_req));
endmodule

// File: rtl/uncal_lane_detect.sv
module uncal_lane_detect #(
    parameter int NUM_RANKS    = 8,
    parameter int BITMAP_BYTES = 10,
    parameter int IDX_W        = 8,
    localparam int RANK_W      = $clog2(NUM_RANKS),
    localparam int CNT_W       = $clog2(NUM_RANKS + 1),
    localparam int BYTE_W      = $clog2(BITMAP_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   width_x8,
    input  logic [IDX_W-1:0]       dram_idx,
    input  logic [8*NUM_RANKS-1:0] rank_pair,
    input  logic [CNT_W-1:0]       rank_cnt,
    output logic                   rd_req,
    output logic [RANK_W-1:0]      rd_rank,
    output logic [BYTE_W-1:0]      rd_byte,
    input  logic [7:0]             rd_data,
    output logic                   busy,
    output logic                   done,
    output logic                   uncal,
    output logic                   oob_err,
    output logic [7:0]             clr_mask
);
    logic [BYTE_W-1:0] sel_byte;
    logic [7:0]        sel_det;
    logic [7:0]        sel_clr;
    logic              sel_oob;

    uld_lane_sel #(
        .IDX_W        (IDX_W),
        .BITMAP_BYTES (BITMAP_BYTES)
    ) lane_sel_i (
        .width_x8 (width_x8),
        .dram_idx (dram_idx),
        .byte_idx (sel_byte),
        .det_mask (sel_det),
        .clr_mask (sel_clr),
        .oob      (sel_oob)
    );

    uld_rank_scan #(
        .NUM_RANKS    (NUM_RANKS),
        .BITMAP_BYTES (BITMAP_BYTES)
    ) rank_scan_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .rank_pair   (rank_pair),
        .rank_cnt    (rank_cnt),
        .byte_idx    (sel_byte),
        .det_mask    (sel_det),
        .clr_mask_in (sel_clr),
        .oob         (sel_oob),
        .rd_req      (rd_req),
        .rd_rank     (rd_rank),
        .rd_byte     (rd_byte),
        .rd_data     (rd_data),
        .busy        (busy),
        .done        (done),
        .uncal       (uncal),
        .oob_err     (oob_err),
        .clr_mask    (clr_mask)
    );
endmodule

// File: tb/uncal_lane_detect_tb.sv
module uncal_lane_detect_tb_top;
    localparam int NR = 8;
    localparam int NB = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          width_x8 = 1'b1;
    logic [7:0]    dram_idx = '0;
    logic [8*NR-1:0] rank_pair = '0;
    logic [3:0]    rank_cnt = 4'd8;
    logic          rd_req;
    logic [2:0]    rd_rank;
    logic [3:0]    rd_byte;
    logic [7:0]    rd_data = '0;
    logic          busy, done, uncal, oob_err;
    logic [7:0]    clr_mask;

    int checks = 0;
    int errors = 0;
    logic [7:0] bad [NR][16];

    typedef struct packed {
        logic       uncal;
        logic       err;
        logic [7:0] clr;
    } exp_t;
    exp_t exp_q[$];

    int reads;
    int last_rank;
    int exp_byte;
    int done_seen;

    always #10 clk = ~clk;

    uncal_lane_detect dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .width_x8(width_x8),
        .dram_idx(dram_idx), .rank_pair(rank_pair), .rank_cnt(rank_cnt),
        .rd_req(rd_req), .rd_rank(rd_rank), .rd_byte(rd_byte), .rd_data(rd_data),
        .busy(busy), .done(done), .uncal(uncal), .oob_err(oob_err),
        .clr_mask(clr_mask)
    );

    always @(posedge clk) if (rd_req) rd_data <= bad[rd_rank][rd_byte];

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // read-port monitor
    always @(negedge clk) begin
        if (rst_n && rd_req) begin
            reads++;
            check(rank_pair[8*rd_rank +: 8] != 8'd255, "R5 read of unconfigured rank", rd_rank, 0);
            check(int'(rd_rank) > last_rank, "R10 ascending order", rd_rank, last_rank + 1);
            check(int'(rd_byte) == exp_byte, "R2/R3 byte index", rd_byte, exp_byte);
            last_rank = rd_rank;
        end
    end

    // result monitor
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_seen++;
            if (exp_q.size() == 0) begin
                check(0, "R10 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(uncal == e.uncal, "R6/R7 verdict", uncal, e.uncal);
                check(oob_err == e.err, "R9 error flag", oob_err, e.err);
                check(clr_mask == e.clr, "R8 clear mask", clr_mask, e.clr);
            end
        end
    end

    function automatic exp_t model(input bit x8, input int idx, input logic [8*NR-1:0] pr, input int cnt);
        exp_t e;
        int b;
        logic [7:0] m;
        b = x8 ? idx : idx / 2;
        m = x8 ? 8'hFF : ((idx % 2 == 0) ? 8'hF0 : 8'h0F);
        e.clr = x8 ? 8'h00 : ((idx % 2 == 0) ? 8'h0F : 8'hF0);
        e.err = b >= NB;
        e.uncal = 1'b0;
        if (!e.err && cnt != 1) begin
            e.uncal = 1'b1;
            for (int r = 0; r < NR; r++) begin
                if (pr[8*r +: 8] != 8'd255 && ((bad[r][b] & m) != m)) begin
                    e.uncal = 1'b0;
                    break;
                end
            end
        end
        return e;
    endfunction

    task automatic run_op(input bit x8, input int idx, input logic [8*NR-1:0] pr,
                          input int cnt, input int exp_reads, input string tag);
        int d0;
        exp_q.push_back(model(x8, idx, pr, cnt));
        exp_byte  = x8 ? idx : idx / 2;
        reads     = 0;
        last_rank = -1;
        d0        = done_seen;
        @(negedge clk);
        width_x8  = x8;
        dram_idx  = 8'(idx);
        rank_pair = pr;
        rank_cnt  = 4'(cnt);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_seen == d0) @(negedge clk);
        @(negedge clk);
        check(!done, {tag, " R10 done single pulse"}, done, 0);
        if (exp_reads >= 0)
            check(reads == exp_reads, {tag, " read count"}, reads, exp_reads);
    endtask

    function automatic logic [8*NR-1:0] all_pairs();
        logic [8*NR-1:0] p;
        for (int r = 0; r < NR; r++) p[8*r +: 8] = 8'(r / 2);
        return p;
    endfunction

    task automatic fill(input int b, input logic [7:0] v);
        for (int r = 0; r < NR; r++) bad[r][b] = v;
    endtask

    initial begin
        logic [8*NR-1:0] pr;
        for (int r = 0; r < NR; r++)
            for (int b = 0; b < 16; b++) bad[r][b] = 8'h00;
        repeat (3) @(negedge clk);
        check(!done && !busy && !rd_req, "R10 reset state", {done, busy, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 R2 R4: x8 all fully bad
        fill(3, 8'hFF);
        run_op(1, 3, all_pairs(), 8, 8, "R7 x8 full");
        // R6: x8 rank 5 partly good, stop after rank 5
        bad[5][3] = 8'hFE;
        run_op(1, 3, all_pairs(), 8, 6, "R6 x8 early stop");
        // R3 R4: x4 even index 4 -> byte 2, mask F0
        fill(2, 8'hF0);
        run_op(0, 4, all_pairs(), 8, 8, "R4 x4 even bad");
        run_op(0, 5, all_pairs(), 8, 1, "R4 x4 odd good");
        fill(2, 8'h0F);
        run_op(0, 5, all_pairs(), 8, 8, "R4 x4 odd bad");
        run_op(0, 4, all_pairs(), 8, 1, "R4 x4 even good");
        // R5: unconfigured ranks hold good bits but are skipped
        fill(7, 8'hFF);
        bad[2][7] = 8'h00;
        bad[6][7] = 8'h00;
        pr = all_pairs();
        pr[8*2 +: 8] = 8'd255;
        pr[8*6 +: 8] = 8'd255;
        run_op(1, 7, pr, 6, 6, "R5 skip");
        // R7: no configured rank at all
        run_op(1, 0, '1, 0, 0, "R7 none configured");
        // R1: single-rank port
        run_op(1, 7, all_pairs(), 1, 0, "R1 single rank");
        // R9: boundaries
        fill(9, 8'hFF);
        run_op(1, 9, all_pairs(), 8, 8, "R9 x8 last byte");
        run_op(1, 10, all_pairs(), 8, 0, "R9 x8 oob");
        run_op(0, 19, all_pairs(), 8, 8, "R9 x4 last");
        run_op(0, 20, all_pairs(), 8, 0, "R9 x4 oob");
        // R11: second start while busy is ignored
        exp_q.push_back(model(1, 3, all_pairs(), 8));
        exp_byte = 3; reads = 0; last_rank = -1;
        @(negedge clk);
        width_x8 = 1; dram_idx = 8'd3; rank_pair = all_pairs(); rank_cnt = 4'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        width_x8 = 0; dram_idx = 8'd40; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            int d0;
            d0 = done_seen;
            while (done_seen == d0) @(negedge clk);
        end
        @(negedge clk);
        check(exp_q.size() == 0 && !busy, "R11 ignored start", busy, 0);
        check(reads == 6, "R11 scan unchanged", reads, 6);
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule